// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block turns a fast reference clock into the two timing strobes a serial transmitter and receiver need. The first strobe is the sample tick, which marks oversampling points. The second is the bit tick, which marks bit boundaries. Both strobes are single-cycle enables in the reference clock domain, so no derived clock is created.

The optional divide-by-8 prescaler is also a clock enable. When `prescale_sel` is low, every reference cycle counts. When it is high, only every eighth reference cycle counts. The first counter divides the counted cycles by the clock divisor `clk_div` and produces the sample tick. The second counter divides sample ticks by `bit_div + 1` and produces the bit tick. The resulting bit rate is the selected clock divided by `clk_div * (bit_div + 1)`.

Normal settings are a clock divisor of 2 to 65535 and a bit divisor of 4 to 254. With a 100 MHz reference this covers roughly 6 bit/s up to 10 Mbit/s. Choosing divisor values from a target rate is left to software. Any change to the divisor or prescale inputs restarts the whole chain from zero, so no shortened period is produced after a change.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, `sample_tick` and `bit_tick` are both 0.
- R2: With `prescale_sel` = 0 and a stable `clk_div` = N (N >= 1), `sample_tick` is high once every N reference cycles.
- R3: With `prescale_sel` = 1 and a stable `clk_div` = N (N >= 1), `sample_tick` is high once every 8*N reference cycles.
- R4: `bit_tick` is high only in cycles where `sample_tick` is also high. It is high on every (`bit_div` + 1)-th sample tick, so with `bit_div` = 0 it equals `sample_tick`.
- R5: With `clk_div` = 0, neither tick is ever asserted.
- R6: With `clk_div` = 1 and `prescale_sel` = 0, `sample_tick` stays high in every cycle after the first cycle that follows a restart.
- R7: A change of `clk_div`, `bit_div` or `prescale_sel`, or the release of reset, restarts all counters, and both ticks are low in the first cycle after the change. Counting cycles from the clock edge that samples the new value as edge 1, the first sample tick is high after edge P and the first bit tick is high after edge P*(`bit_div`+1). Here P = `clk_div` for `prescale_sel` = 0 and P = 8*`clk_div` for `prescale_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prescale_sel | input | 1 | 1 selects the divide-by-8 prescale enable, 0 counts every cycle |
| clk_div | input | CD_W (16) | Clock divisor for the sample tick, 0 stops both ticks |
| bit_div | input | BD_W (8) | Bit divisor minus one: sample ticks per bit tick, minus one |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit-rate strobe |

## Verification
A wrong counter state in this block shows up at the ports as a tick that arrives early or late relative to the last restart. It is therefore visible no later than the first expected tick position, which is one sample period or one bit period after the change. The bench relates every cycle's expected tick value to the cycle count since each reconfiguration. It sweeps all prescale settings with small divisors, including 0 and 1, and reconfigures in the middle of periods. A stale prescaler or bit counter that survives a restart shifts the first tick, and this is caught within one bit period. The full-width clock divisor exposes a counter that wraps too early.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
   localparam int unsigned BG_PRESCALE_DEFAULT = 8;

   function automatic bit bg_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/bg_prescale.sv
module bg_prescale #(
   parameter int unsigned PRE_RATIO = baud_gen_pkg::BG_PRESCALE_DEFAULT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic sel,
   output logic en_o
);
   localparam int unsigned PW = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRE_RATIO - 1);

   logic [PW-1:0] cnt;

   generate
      if (PRE_RATIO < 2) begin : g_bad_ratio
         $error("bg_prescale: PRE_RATIO must be at least 2");
      end

      if (baud_gen_pkg::bg_is_pow2(PRE_RATIO)) begin : g_wrap
         // power-of-two ratio: counter wraps naturally
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (clr)   cnt <= '0;
            else if (sel)   cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (clr)   cnt <= '0;
            else if (sel)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
   endgenerate

   assign en_o = !sel || (cnt == LAST);
endmodule

// File: rtl/bg_sample_div.sv
module bg_sample_div #(
   parameter int unsigned CD_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            en_i,
   input  logic [CD_W-1:0] cd_i,
   output logic            tick_o
);
   logic [CD_W-1:0] cnt;
   logic            active;
   logic            last;

   assign active = (cd_i != '0);
   assign last   = (cnt == (cd_i - CD_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (en_i && active)    cnt <= last ? '0 : cnt + 1'b1;
   end

   assign tick_o = en_i && active && last && !clr;
endmodule

// File: rtl/bg_bit_div.sv
module bg_bit_div #(
   parameter int unsigned BD_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            en_i,
   input  logic [BD_W-1:0] bd_i,
   output logic            tick_o
);
   logic [BD_W-1:0] cnt;
   logic            last;

   assign last = (cnt == bd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (en_i)    cnt <= last ? '0 : cnt + 1'b1;
   end

   assign tick_o = en_i && last && !clr;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
   parameter int unsigned CD_W      = 16,
   parameter int unsigned BD_W      = 8,
   parameter int unsigned PRE_RATIO = baud_gen_pkg::BG_PRESCALE_DEFAULT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            prescale_sel,
   input  logic [CD_W-1:0] clk_div,
   input  logic [BD_W-1:0] bit_div,
   output logic            sample_tick,
   output logic            bit_tick
);
   localparam int unsigned CFG_W = 1 + CD_W + BD_W;

   generate
      if (CD_W < 2) begin : g_bad_cd
         $error("baud_tick_gen: CD_W must be at least 2");
      end
      if (BD_W < 1) begin : g_bad_bd
         $error("baud_tick_gen: BD_W must be at least 1");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;
   logic             run_q;
   logic             restart;
   logic             pre_en;
   logic             s_tick;

   assign cfg_now = {prescale_sel, clk_div, bit_div};
   assign restart = !run_q || (cfg_now != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         run_q <= 1'b0;
      end else begin
         cfg_q <= cfg_now;
         run_q <= 1'b1;
      end
   end

   bg_prescale #(.PRE_RATIO(PRE_RATIO)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .sel   (prescale_sel),
      .en_o  (pre_en)
   );

   bg_sample_div #(.CD_W(CD_W)) u_sdiv (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (restart),
      .en_i   (pre_en),
      .cd_i   (clk_div),
      .tick_o (s_tick)
   );

   bg_bit_div #(.BD_W(BD_W)) u_bdiv (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (restart),
      .en_i   (s_tick),
      .bd_i   (bit_div),
      .tick_o (bit_tick)
   );

   assign sample_tick = s_tick;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
   parameter int unsigned CD_W = 16,
   parameter int unsigned BD_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            prescale_sel,
   input logic [CD_W-1:0] clk_div,
   input logic [BD_W-1:0] bit_div,
   input logic            sample_tick,
   input logic            bit_tick
);
   // R1: quiet while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!sample_tick && !bit_tick);
      end
   end

   a_r4_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick);

   a_r5_cd_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_div == '0) |-> (!sample_tick && !bit_tick));

   a_r7_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((clk_div != $past(clk_div)) || (bit_div != $past(bit_div)) ||
       (prescale_sel != $past(prescale_sel))) |-> (!sample_tick && !bit_tick));

   a_r6_cd_one_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !prescale_sel && (clk_div == CD_W'(1)) &&
       $stable(clk_div) && $stable(bit_div) && $stable(prescale_sel)) |-> sample_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CD_W(CD_W), .BD_W(BD_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .prescale_sel (prescale_sel),
   .clk_div      (clk_div),
   .bit_div      (bit_div),
   .sample_tick  (sample_tick),
   .bit_tick     (bit_tick)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prescale_sel = 1'b0;
   logic [15:0] clk_div = 16'd0;
   logic [7:0]  bit_div = 8'd0;
   logic        sample_tick;
   logic        bit_tick;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   baud_tick_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .prescale_sel (prescale_sel),
      .clk_div      (clk_div),
      .bit_div      (bit_div),
      .sample_tick  (sample_tick),
      .bit_tick     (bit_tick)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Apply a configuration at a falling edge and compare every cycle
   // against the arithmetic tick schedule for `window` cycles.
   task automatic run_cfg(input bit sel, input int cd, input int bd, input int window);
      longint ps, pb;
      int bad_s = 0, bad_b = 0, first_s = -1, first_b = -1, cnt_s = 0, cnt_b = 0;
      int exp_cnt_s, exp_cnt_b;
      string sreq;
      ps = (sel ? 8 : 1) * cd;
      pb = ps * (bd + 1);
      prescale_sel = sel;
      clk_div = 16'(cd);
      bit_div = 8'(bd);
      for (int k = 1; k <= window; k++) begin
         bit es, eb;
         @(negedge clk);
         es = (cd != 0) && ((k % ps) == 0);
         eb = (cd != 0) && ((k % pb) == 0);
         if (sample_tick !== es) bad_s++;
         if (bit_tick !== eb) bad_b++;
         if (sample_tick) begin cnt_s++; if (first_s < 0) first_s = k; end
         if (bit_tick) begin cnt_b++; if (first_b < 0) first_b = k; end
      end
      exp_cnt_s = (cd == 0) ? 0 : int'(window / ps);
      exp_cnt_b = (cd == 0) ? 0 : int'(window / pb);
      if (cd == 0) sreq = "R5";
      else if (cd == 1 && !sel) sreq = "R6";
      else if (sel) sreq = "R3";
      else sreq = "R2";
      check(bad_s == 0 && cnt_s == exp_cnt_s, sreq, cnt_s, exp_cnt_s);
      check(bad_b == 0 && cnt_b == exp_cnt_b, "R4", cnt_b, exp_cnt_b);
      if (cd != 0) begin
         check(first_s == ps, "R7 first sample tick", first_s, ps);
         if (pb <= window) check(first_b == pb, "R7 first bit tick", first_b, pb);
      end
   endtask

   initial begin
      // R1: ticks held low during reset with an active configuration
      clk_div = 16'd1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(!sample_tick && !bit_tick, "R1 reset", {sample_tick, bit_tick}, 0);
      end
      clk_div = 16'd0;
      @(negedge clk);
      rst_n = 1'b1;
      // near-exhaustive sweep of small divisors; each new config
      // lands mid-period of the previous one (R7 restart)
      for (int s = 0; s < 2; s++) begin
         for (int cd = 0; cd <= 5; cd++) begin
            for (int bd = 0; bd <= 5; bd++) begin
               int w;
               w = (cd == 0) ? 20 : ((s != 0) ? 8 : 1) * cd * (bd + 1) * 2 + 3;
               run_cfg(s[0], cd, bd, w);
            end
         end
      end
      // large divisors: wide counters, no bit tick inside window
      run_cfg(1'b0, 1000, 254, 2100);
      // full-width clock divisor, bit tick equal to sample tick (R4)
      run_cfg(1'b0, 65535, 0, 65540);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 190000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule